// File: doc/BRIEF.md
# Ethernet Link Activity LED Driver

This block turns PHY status flags into two active-low indicator outputs. The link/activity output lights steadily while a valid link is present. Each transmit or receive activity strobe makes it blink: it goes dark for one fixed blink interval, then stays lit for at least one more full interval before a new blink may begin. Strobes that arrive while a blink is running are remembered, so continuous traffic gives an even dark/lit cadence instead of a stretched or lost indication.

The speed output is decoded from the PHY state. It lights for 100 Mb/s operation and while auto-negotiation runs. It stays dark for 10 Mb/s operation and whenever the line is isolated. The blink interval is a whole number of clock cycles computed from a clock-frequency parameter and a millisecond parameter (80 ms by default). A non-zero override parameter replaces that count with a short value for simulation.

Top module: `lled_top`

## Requirements
- R1: While reset is applied, and in the cycle after it is released, both `led_link_n` and `led_speed_n` are 1 (dark).
- R2: While `link_up` is 0, `led_link_n` is 1 one cycle later and stays 1, and `tx_act`/`rx_act` strobes are ignored: after link returns, no blink results from them.
- R3: One cycle after `link_up` rises, with no activity, `led_link_n` is 0 and stays 0 while there is no activity.
- R4: A one-cycle strobe on `tx_act` or `rx_act` while the output is steadily lit makes `led_link_n` 1 in the next cycle and keeps it 1 for exactly P cycles. P is `PERIOD_OVR` when that is non-zero, otherwise `CLK_HZ/1000*BLINK_MS`.
- R5: After the dark interval, `led_link_n` is 0 for at least P cycles, even if activity arrives during that time.
- R6: A strobe that arrives during the dark interval or the minimum lit interval is latched, and a new dark interval starts in the cycle right after the minimum lit interval ends.
- R7: If no strobe arrived during the dark or minimum lit interval, `led_link_n` stays 0 after the minimum lit interval.
- R8: Dropping `link_up` during a blink aborts it: `led_link_n` is 1 next cycle. On relink the output is steadily lit, with no pending blink carried over.
- R9: When `line_iso` is 0 and either `speed_100` or `aneg_busy` is 1, `led_speed_n` is 0 one cycle later.
- R10: When `line_iso` is 1, or when `speed_100` and `aneg_busy` are both 0, `led_speed_n` is 1 one cycle later. Isolation overrides speed and negotiation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| link_up | input | 1 | 1 while the PHY reports a valid link |
| tx_act | input | 1 | One-cycle transmit activity strobe |
| rx_act | input | 1 | One-cycle receive activity strobe |
| speed_100 | input | 1 | 1 when the link runs at 100 Mb/s, 0 for 10 Mb/s |
| aneg_busy | input | 1 | 1 while auto-negotiation is in progress |
| line_iso | input | 1 | 1 while the line is isolated |
| led_link_n | output | 1 | Link/activity indicator, active low |
| led_speed_n | output | 1 | Speed indicator, active low |

## Verification
The blink sequencer is driven with a single transmit strobe, a single receive strobe, a strobe during the dark interval, and a strobe during the minimum lit interval. The single strobes pin down the exact length of both intervals and the return to steady light. The two late strobes show that activity is latched, and that it starts the next blink at the end of the lit interval rather than cutting the interval short. Link loss in mid-blink, and strobes while the link is down, separate a clean abort from leftover pending state. The speed decoder is walked through all combinations that matter, so that isolation priority over speed and negotiation is visible.

// File: rtl/lled_pkg.sv
package lled_pkg;

    typedef enum logic [1:0] {
        BL_DARK  = 2'd0,
        BL_SOLID = 2'd1,
        BL_OFF   = 2'd2,
        BL_HOLD  = 2'd3
    } blink_st_e;

    typedef struct packed {
        logic fast;
        logic negotiating;
        logic isolated;
    } phy_spd_t;

    // Cycles in one blink interval; a non-zero override wins.
    function automatic int unsigned calc_period(input int unsigned clk_hz,
                                                input int unsigned ms,
                                                input int unsigned ovr);
        if (ovr != 0)
            return ovr;
        return (clk_hz / 1000) * ms;
    endfunction

    function automatic logic spd_lit(input phy_spd_t s);
        return !s.isolated && (s.fast || s.negotiating);
    endfunction

endpackage

// File: rtl/lled_interval.sv
module lled_interval #(
    parameter int unsigned PERIOD = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic restart,
    output logic expired
);
    localparam int unsigned CW = (PERIOD > 2) ? $clog2(PERIOD) : 1;
    localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (restart)
            cnt <= '0;
        else if (cnt != LAST)
            cnt <= cnt + 1'b1;
    end

    assign expired = (cnt == LAST);

    // R4: the interval count never runs past its terminal value
    assert_cnt_bound_R4: assert property (@(posedge clk) disable iff (rst)
        cnt <= LAST);

    // R4: a restart always begins a fresh interval that is not yet over
    assert_restart_fresh_R4: assert property (@(posedge clk) disable iff (rst)
        restart |=> (PERIOD == 1) || !expired);

endmodule

// File: rtl/lled_pending.sv
module lled_pending (
    input  logic clk,
    input  logic rst,
    input  logic link_up,
    input  logic act_now,
    input  logic consume,
    output logic pend
);
    always_ff @(posedge clk) begin
        if (rst || !link_up)
            pend <= 1'b0;
        else if (consume)
            pend <= 1'b0;
        else if (act_now)
            pend <= 1'b1;
    end

    // R6: activity that is not used at once is kept for the next blink
    assert_latch_act_R6: assert property (@(posedge clk) disable iff (rst)
        (link_up && act_now && !consume) |=> pend);

    // R2: nothing is remembered across a link loss
    assert_drop_on_nolink_R2: assert property (@(posedge clk) disable iff (rst)
        !link_up |=> !pend);

endmodule

// File: rtl/lled_blink_fsm.sv
module lled_blink_fsm
    import lled_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic link_up,
    input  logic act_now,
    input  logic pend,
    input  logic expired,
    output logic restart,
    output logic consume,
    output logic led_n
);
    blink_st_e st, st_nxt;
    logic      trig;

    assign trig = pend || act_now;

    always_comb begin
        st_nxt  = st;
        restart = 1'b0;
        consume = 1'b0;
        case (st)
            BL_DARK: begin
                if (link_up)
                    st_nxt = BL_SOLID;
            end
            BL_SOLID: begin
                if (trig) begin
                    st_nxt  = BL_OFF;
                    restart = 1'b1;
                    consume = 1'b1;
                end
            end
            BL_OFF: begin
                if (expired) begin
                    st_nxt  = BL_HOLD;
                    restart = 1'b1;
                end
            end
            BL_HOLD: begin
                if (expired) begin
                    if (trig) begin
                        st_nxt  = BL_OFF;
                        restart = 1'b1;
                        consume = 1'b1;
                    end else begin
                        st_nxt = BL_SOLID;
                    end
                end
            end
            default: st_nxt = BL_DARK;
        endcase
        if (!link_up) begin
            st_nxt  = BL_DARK;
            restart = 1'b0;
            consume = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            st <= BL_DARK;
        else
            st <= st_nxt;
    end

    assign led_n = (st == BL_DARK) || (st == BL_OFF);

    // R2 / R8: without link the indicator is dark on the next cycle
    assert_nolink_dark_R2: assert property (@(posedge clk) disable iff (rst)
        !link_up |=> led_n);

    // R5: the minimum lit interval is not cut short while link stays up
    assert_hold_kept_R5: assert property (@(posedge clk) disable iff (rst)
        (st == BL_HOLD && !expired && link_up) |=> (st == BL_HOLD && !led_n));

    // R4: a dark interval is only ever followed by the lit hold or link loss
    assert_off_then_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (st == BL_OFF && expired && link_up) |=> (st == BL_HOLD));

endmodule

// File: rtl/lled_speed_dec.sv
module lled_speed_dec
    import lled_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  phy_spd_t stat,
    output logic     led_n
);
    always_ff @(posedge clk) begin
        if (rst)
            led_n <= 1'b1;
        else
            led_n <= !spd_lit(stat);
    end

    // R10: isolation forces the speed indicator dark
    assert_iso_dark_R10: assert property (@(posedge clk) disable iff (rst)
        stat.isolated |=> led_n);

    // R9: fast link or negotiation lights it when not isolated
    assert_fast_lit_R9: assert property (@(posedge clk) disable iff (rst)
        (!stat.isolated && (stat.fast || stat.negotiating)) |=> !led_n);

endmodule

// File: rtl/lled_top.sv
module lled_top
    import lled_pkg::*;
#(
    parameter int unsigned CLK_HZ     = 200_000_000,
    parameter int unsigned BLINK_MS   = 80,
    parameter int unsigned PERIOD_OVR = 0
) (
    input  logic clk,
    input  logic rst,
    input  logic link_up,
    input  logic tx_act,
    input  logic rx_act,
    input  logic speed_100,
    input  logic aneg_busy,
    input  logic line_iso,
    output logic led_link_n,
    output logic led_speed_n
);
    localparam int unsigned PERIOD = calc_period(CLK_HZ, BLINK_MS, PERIOD_OVR);

    logic     act_now;
    logic     pend;
    logic     expired;
    logic     restart;
    logic     consume;
    phy_spd_t spd_stat;

    assign act_now = tx_act || rx_act;

    assign spd_stat.fast        = speed_100;
    assign spd_stat.negotiating = aneg_busy;
    assign spd_stat.isolated    = line_iso;

    lled_interval #(.PERIOD(PERIOD)) u_interval (
        .clk     (clk),
        .rst     (rst),
        .restart (restart),
        .expired (expired)
    );

    lled_pending u_pending (
        .clk     (clk),
        .rst     (rst),
        .link_up (link_up),
        .act_now (act_now),
        .consume (consume),
        .pend    (pend)
    );

    lled_blink_fsm u_fsm (
        .clk     (clk),
        .rst     (rst),
        .link_up (link_up),
        .act_now (act_now),
        .pend    (pend),
        .expired (expired),
        .restart (restart),
        .consume (consume),
        .led_n   (led_link_n)
    );

    lled_speed_dec u_speed (
        .clk   (clk),
        .rst   (rst),
        .stat  (spd_stat),
        .led_n (led_speed_n)
    );

    // R1: both indicators dark in the cycle after reset
    assert_reset_dark_R1: assert property (@(posedge clk)
        rst |=> (led_link_n && led_speed_n));

endmodule

// File: tb/lled_top_tb_top.sv
module lled_top_tb_top;

    localparam int P = 20;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic link_up = 1'b0, tx_act = 1'b0, rx_act = 1'b0;
    logic speed_100 = 1'b0, aneg_busy = 1'b0, line_iso = 1'b0;
    logic led_link_n, led_speed_n;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    lled_top #(.CLK_HZ(200_000_000), .BLINK_MS(80), .PERIOD_OVR(P)) dut_i (
        .clk(clk), .rst(rst), .link_up(link_up), .tx_act(tx_act),
        .rx_act(rx_act), .speed_100(speed_100), .aneg_busy(aneg_busy),
        .line_iso(line_iso), .led_link_n(led_link_n), .led_speed_n(led_speed_n)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    // one-cycle strobe; returns at the first negedge after it was sampled
    task automatic strobe(input logic t, input logic r);
        tx_act = t; rx_act = r;
        wait_n(1);
        tx_act = 1'b0; rx_act = 1'b0;
    endtask

    task automatic t_reset_R1;
        rst = 1'b1;
        wait_n(3);
        chk("R1 link led in reset", led_link_n, 1'b1);
        chk("R1 speed led in reset", led_speed_n, 1'b1);
        rst = 1'b0;
        wait_n(1);
        chk("R1 link led after reset", led_link_n, 1'b1);
        chk("R1 speed led after reset", led_speed_n, 1'b1);
    endtask

    task automatic t_link_R3;
        link_up = 1'b1;
        wait_n(1);
        chk("R3 lit one cycle after link", led_link_n, 1'b0);
        wait_n(2 * P);
        chk("R3 stays lit without activity", led_link_n, 1'b0);
    endtask

    task automatic t_single_blink(input logic t, input logic r, input string tag);
        strobe(t, r);
        chk({tag, " R4 dark next cycle"}, led_link_n, 1'b1);
        wait_n(P - 1);
        chk({tag, " R4 dark at last cycle"}, led_link_n, 1'b1);
        wait_n(1);
        chk({tag, " R4/R5 lit after P cycles"}, led_link_n, 1'b0);
        wait_n(P - 1);
        chk({tag, " R5 lit through hold"}, led_link_n, 1'b0);
        wait_n(1);
        chk({tag, " R7 solid after hold"}, led_link_n, 1'b0);
        wait_n(P);
        chk({tag, " R7 still solid"}, led_link_n, 1'b0);
    endtask

    task automatic t_act_in_hold_R6;
        strobe(1'b0, 1'b1);
        wait_n(P + 4);
        strobe(1'b1, 1'b0);          // now at N(P+6), inside hold
        chk("R5 hold not cut by activity", led_link_n, 1'b0);
        wait_n(P - 6);
        chk("R5 lit at end of hold", led_link_n, 1'b0);
        wait_n(1);
        chk("R6 blink after hold from latched strobe", led_link_n, 1'b1);
        wait_n(P - 1);
        chk("R6 second blink full length", led_link_n, 1'b1);
        wait_n(1);
        chk("R6 second blink ends", led_link_n, 0);
        wait_n(2 * P);
    endtask

    task automatic t_act_in_off_R6;
        strobe(1'b1, 1'b0);
        wait_n(2);
        strobe(1'b1, 1'b0);          // now at N4, inside dark interval
        chk("R6 still dark", led_link_n, 1'b1);
        wait_n(P - 3);
        chk("R4 dark not extended by strobe", led_link_n, 1'b0);
        wait_n(P - 1);
        chk("R5 lit to end of hold", led_link_n, 1'b0);
        wait_n(1);
        chk("R6 latched strobe starts next blink", led_link_n, 1'b1);
        wait_n(2 * P);
        chk("R7 solid after repeated blink", led_link_n, 1'b0);
    endtask

    task automatic t_link_loss_R8;
        strobe(1'b1, 1'b0);
        wait_n(3);
        tx_act = 1'b1;               // would be latched if link stayed
        link_up = 1'b0;
        wait_n(1);
        tx_act = 1'b0;
        chk("R8 dark after link loss", led_link_n, 1'b1);
        wait_n(P + 5);
        chk("R2 dark while no link", led_link_n, 1'b1);
        strobe(1'b0, 1'b1);
        chk("R2 strobe ignored while down", led_link_n, 1'b1);
        link_up = 1'b1;
        wait_n(1);
        chk("R8 solid on relink", led_link_n, 1'b0);
        wait_n(2);
        chk("R2 no blink from strobes while down", led_link_n, 1'b0);
        wait_n(2 * P);
        chk("R8 no pending blink carried over", led_link_n, 1'b0);
    endtask

    task automatic spd(input logic f, input logic a, input logic i,
                       input logic exp, input string tag);
        speed_100 = f; aneg_busy = a; line_iso = i;
        wait_n(1);
        chk(tag, led_speed_n, exp);
    endtask

    task automatic t_speed;
        spd(1'b1, 1'b0, 1'b0, 1'b0, "R9 100M lit");
        spd(1'b0, 1'b0, 1'b0, 1'b1, "R10 10M dark");
        spd(1'b0, 1'b1, 1'b0, 1'b0, "R9 negotiating lit");
        spd(1'b1, 1'b1, 1'b1, 1'b1, "R10 isolate overrides");
        spd(1'b0, 1'b1, 1'b1, 1'b1, "R10 isolate over negotiation");
        spd(1'b1, 1'b0, 1'b0, 1'b0, "R9 100M lit again");
    endtask

    initial begin
        wait_n(1);
        t_reset_R1();
        t_link_R3();
        t_single_blink(1'b1, 1'b0, "tx");
        t_single_blink(1'b0, 1'b1, "rx");
        t_act_in_hold_R6();
        t_act_in_off_R6();
        t_link_loss_R8();
        t_speed();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule